// File: doc/BRIEF.md
# Composite Video Line Serializer

This block turns a stream of packed pixel words into a sequence of 3-bit DAC level codes for one composite video line. It has two down-counters that step only on a single-cycle video clock enable. A frame counter sets how many video clocks each loaded pixel/palette word lasts. A pixel counter sets how many video clocks each pixel within that word lasts. Each pixel carries a 2-bit selector that picks one of four 8-bit palette entries, and the low three bits of the chosen entry are driven out as the level code.

A control processor first writes a configuration word together with the frame and pixel clock counts. It then presents pixel and palette words on the data buses and holds each word valid until the block takes it. The block reads the buses only when a frame ends, and it pulses an acknowledge in the same cycle that the new word starts to show at the output. Colour modulation, clock synthesis and the analogue converter are not part of the block.

Top module: `cvid_line_gen`

## Requirements
- R1: While reset is asserted and right after it, `level_o` is 0, `ack_o` is 0, `wait_o` is 0 and the block is halted.
- R2: A configuration write with a nonzero mode word, issued while the block is halted, starts the block with its frame counter at zero. The first frame therefore ends after exactly 4096 enabled video clocks, whatever value the frame clock count holds.
- R3: A configuration write with an all-zero mode word halts both counters. While the block is halted, `level_o` holds its value and `ack_o` stays low. A later nonzero write restarts the block with another 4096-clock first frame.
- R4: When a frame ends, the block loads the pixel word and the palette word from the buses as they stand at that edge, whether or not `data_vld_i` is high. `ack_o` is high for the single cycle after that edge only if `data_vld_i` was high at the edge.
- R5: Every frame after the first lasts `cfg_fclk_i` enabled clocks, using the value written last before the frame began. The value 0 means 4096.
- R6: Pixel n of the pixel word sits at bits [2n+1:2n], and pixel 0 is output first. The output moves to the next pixel after `cfg_pclk_i` enabled clocks, where 0 means 256.
- R7: Once the last of the 16 pixels is reached, that pixel stays on the output until the frame ends.
- R8: A 2-bit selector value k picks palette entry k at bits [8k+7:8k] of the palette word. `level_o` equals bits [2:0] of that entry.
- R9: Neither counter moves on a clock in which `vid_en_i` is low.
- R10: `wait_o` is high exactly when the block is running and `data_vld_i` is low.
- R11: Given words with level 0, 2, 7 and 2 and frame lengths of 354, 1224, 1884 and 1078 clocks, with `vid_en_i` held high, the block produces a test line of exactly those runs: sync, blank, white, blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_en_i | input | 1 | Video clock enable, one cycle per video clock |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 8 | Mode word; all zero halts, nonzero runs |
| cfg_fclk_i | input | 12 | Frame length in video clocks (0 means 4096) |
| cfg_pclk_i | input | 8 | Pixel length in video clocks (0 means 256) |
| data_vld_i | input | 1 | Pixel and palette buses hold a new word |
| pix_word_i | input | 32 | Sixteen 2-bit pixel selectors |
| pal_word_i | input | 32 | Four 8-bit palette entries |
| wait_o | output | 1 | Block is running and waiting for a word |
| ack_o | output | 1 | One-cycle pulse when a valid word is taken |
| level_o | output | 3 | DAC level code |

## Verification
A configuration write, a frame end or a pixel step takes effect on the enabled rising edge that sees it. The new `level_o` and the `ack_o` pulse show one register stage later, so they are valid in the cycle right after that edge. `wait_o` follows `data_vld_i` within the same cycle. The bench drives inputs at falling edges and updates its behavioural model at each rising edge. It compares all three outputs a quarter period after every rising edge, which is where each result is due. Frame lengths are measured by counting the enables the bench itself drove between acknowledges.

// File: rtl/cvid_pkg.sv
package cvid_pkg;
  localparam int unsigned BPP  = 2;
  localparam int unsigned NPAL = 1 << BPP;

  typedef enum logic {
    RUN_OFF = 1'b0,
    RUN_ON  = 1'b1
  } run_state_e;
endpackage

// File: rtl/cvid_frame_ctr.sv
module cvid_frame_ctr #(
  parameter int unsigned FCLK_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [FCLK_W-1:0] len_i,
  output logic              expire_o
);
  logic [FCLK_W-1:0] fcnt_q;

  assign expire_o = tick_i && (fcnt_q == FCLK_W'(1));

  // start from zero: the first decrement wraps, giving a full 2^FCLK_W frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
    end else if (start_i) begin
      fcnt_q <= '0;
    end else if (tick_i) begin
      if (expire_o) fcnt_q <= len_i;
      else          fcnt_q <= fcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cvid_pixel_ctr.sv
module cvid_pixel_ctr #(
  parameter  int unsigned PCLK_W = 8,
  parameter  int unsigned NPIX   = 16,
  localparam int unsigned IDX_W  = $clog2(NPIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [PCLK_W-1:0] len_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  logic [PCLK_W-1:0] pcnt_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      idx_q  <= '0;
    end else if (restart_i) begin
      pcnt_q <= len_i;
      idx_q  <= '0;
    end else if (tick_i) begin
      if (pcnt_q == PCLK_W'(1)) begin
        pcnt_q <= len_i;
        // saturate: last pixel repeats until the frame ends
        if (idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
      end else begin
        pcnt_q <= pcnt_q - 1'b1;
      end
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/cvid_pix_store.sv
module cvid_pix_store
  import cvid_pkg::*;
#(
  parameter  int unsigned NPIX     = 16,
  parameter  int unsigned PAL_W    = 8,
  parameter  int unsigned LVL_W    = 3,
  localparam int unsigned PIX_W    = NPIX * BPP,
  localparam int unsigned PALBUS_W = NPAL * PAL_W,
  localparam int unsigned IDX_W    = $clog2(NPIX)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [PIX_W-1:0]    pix_i,
  input  logic [PALBUS_W-1:0] pal_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [LVL_W-1:0]    level_o
);
  logic [PIX_W-1:0]    pix_q;
  logic [PALBUS_W-1:0] pal_q;
  logic [LVL_W-1:0]    pal_lvl [NPAL];
  logic [BPP-1:0]      sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      pal_q <= '0;
    end else if (load_i) begin
      pix_q <= pix_i;
      pal_q <= pal_i;
    end
  end

  for (genvar k = 0; k < int'(NPAL); k++) begin : g_pal
    assign pal_lvl[k] = pal_q[k*PAL_W +: LVL_W];
  end

  always_comb begin
    sel     = pix_q[int'(idx_i)*BPP +: BPP];
    level_o = pal_lvl[sel];
  end
endmodule

// File: rtl/cvid_line_gen.sv
module cvid_line_gen
  import cvid_pkg::*;
#(
  parameter  int unsigned NPIX     = 16,
  parameter  int unsigned PAL_W    = 8,
  parameter  int unsigned LVL_W    = 3,
  parameter  int unsigned FCLK_W   = 12,
  parameter  int unsigned PCLK_W   = 8,
  parameter  int unsigned CFG_W    = 8,
  localparam int unsigned PIX_W    = NPIX * BPP,
  localparam int unsigned PALBUS_W = NPAL * PAL_W,
  localparam int unsigned IDX_W    = $clog2(NPIX)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vid_en_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_W-1:0]    cfg_mode_i,
  input  logic [FCLK_W-1:0]   cfg_fclk_i,
  input  logic [PCLK_W-1:0]   cfg_pclk_i,
  input  logic                data_vld_i,
  input  logic [PIX_W-1:0]    pix_word_i,
  input  logic [PALBUS_W-1:0] pal_word_i,
  output logic                wait_o,
  output logic                ack_o,
  output logic [LVL_W-1:0]    level_o
);
  run_state_e        run_q;
  logic [FCLK_W-1:0] fclk_q;
  logic [PCLK_W-1:0] pclk_q;
  logic              ack_q;
  logic              run_w;
  logic              start_w;
  logic              tick_w;
  logic              expire_w;
  logic [PCLK_W-1:0] plen_w;
  logic [IDX_W-1:0]  idx_w;

  assign run_w   = (run_q == RUN_ON);
  assign start_w = cfg_wr_i && (cfg_mode_i != '0) && !run_w;
  assign tick_w  = vid_en_i && run_w;
  // on start the pixel counter takes the value being written
  assign plen_w  = start_w ? cfg_pclk_i : pclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= RUN_OFF;
      fclk_q <= '0;
      pclk_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= expire_w && data_vld_i;
      if (cfg_wr_i) begin
        run_q  <= (cfg_mode_i != '0) ? RUN_ON : RUN_OFF;
        fclk_q <= cfg_fclk_i;
        pclk_q <= cfg_pclk_i;
      end
    end
  end

  cvid_frame_ctr #(
    .FCLK_W (FCLK_W)
  ) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .start_i  (start_w),
    .len_i    (fclk_q),
    .expire_o (expire_w)
  );

  cvid_pixel_ctr #(
    .PCLK_W (PCLK_W),
    .NPIX   (NPIX)
  ) u_pixel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .restart_i (start_w || expire_w),
    .len_i     (plen_w),
    .idx_o     (idx_w)
  );

  cvid_pix_store #(
    .NPIX  (NPIX),
    .PAL_W (PAL_W),
    .LVL_W (LVL_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (expire_w),
    .pix_i   (pix_word_i),
    .pal_i   (pal_word_i),
    .idx_i   (idx_w),
    .level_o (level_o)
  );

  assign wait_o = run_w && !data_vld_i;
  assign ack_o  = ack_q;
endmodule

// File: rtl/cvid_line_gen_chk.sv
module cvid_line_gen_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vid_en_i,
  input logic             data_vld_i,
  input logic             run_i,
  input logic             wait_o,
  input logic             ack_o,
  input logic [LVL_W-1:0] level_o
);
  AST_ACK_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(data_vld_i)); // R4

  AST_ACK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(run_i)); // R4

  AST_HALT_HOLDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !$past(run_i)) |-> $stable(level_o)); // R3

  AST_IDLE_TICK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(vid_en_i)) |-> $stable(level_o)); // R9

  AST_ACK_WAIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !$past(wait_o)); // R10
endmodule

bind cvid_line_gen cvid_line_gen_chk #(.LVL_W(LVL_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vid_en_i   (vid_en_i),
  .data_vld_i (data_vld_i),
  .run_i      (run_w),
  .wait_o     (wait_o),
  .ack_o      (ack_o),
  .level_o    (level_o)
);

// File: tb/cvid_line_gen_tb_top.sv
module cvid_line_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vid_en = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_mode = '0;
  logic [11:0] cfg_fclk = '0;
  logic [7:0]  cfg_pclk = '0;
  logic        data_vld = 1'b0;
  logic [31:0] pix_word = '0;
  logic [31:0] pal_word = '0;
  logic        wait_w;
  logic        ack_w;
  logic [2:0]  level_w;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit rand_en = 1'b0;
  bit done = 1'b0;

  bit          m_run = 1'b0;
  bit          m_ack = 1'b0;
  int          m_t = 0;
  int          m_flen = 4096;
  int          m_fclk = 0;
  int          m_pclk = 0;
  logic [31:0] m_pw = '0;
  logic [31:0] m_pl = '0;

  bit rec_arm = 1'b0;
  bit rec_on = 1'b0;
  int rec_q[$];

  always #4 clk = ~clk;

  cvid_line_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vid_en_i   (vid_en),
    .cfg_wr_i   (cfg_wr),
    .cfg_mode_i (cfg_mode),
    .cfg_fclk_i (cfg_fclk),
    .cfg_pclk_i (cfg_pclk),
    .data_vld_i (data_vld),
    .pix_word_i (pix_word),
    .pal_word_i (pal_word),
    .wait_o     (wait_w),
    .ack_o      (ack_w),
    .level_o    (level_w)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int exp_level();
    int plen;
    int idx;
    int sel;
    plen = (m_pclk == 0) ? 256 : m_pclk;
    idx  = m_t / plen;
    if (idx > 15) idx = 15;
    sel = int'((m_pw >> (2 * idx)) & 32'd3);
    return int'((m_pl >> (8 * sel)) & 32'd7);
  endfunction

  // behavioural reference: ticks elapsed in the current frame
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 1'b0; m_ack = 1'b0; m_t = 0; m_flen = 4096;
      m_fclk = 0; m_pclk = 0; m_pw = '0; m_pl = '0;
    end else begin
      m_ack = 1'b0;
      if (m_run && vid_en) begin
        m_t++;
        if (m_t == m_flen) begin
          m_pw = pix_word;
          m_pl = pal_word;
          m_ack = data_vld;
          m_t = 0;
          m_flen = (m_fclk == 0) ? 4096 : m_fclk;
        end
      end
      if (cfg_wr) begin
        if (!m_run && cfg_mode != 0) begin
          m_t = 0;
          m_flen = 4096;
        end
        m_run = (cfg_mode != 0);
        m_fclk = int'(cfg_fclk);
        m_pclk = int'(cfg_pclk);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(int'(level_w) == exp_level(), "R6 R7 R8 R9 level", int'(level_w), exp_level());
      check(ack_w == m_ack, "R4 ack", int'(ack_w), int'(m_ack));
      check(wait_w == (m_run && !data_vld), "R10 wait", int'(wait_w), int'(m_run && !data_vld));
      if (ack_w && rec_arm) begin
        rec_on = 1'b1;
        rec_arm = 1'b0;
      end
      if (rec_on && rec_q.size() < 4541) rec_q.push_back(int'(level_w));
    end
  end

  always @(negedge clk) vid_en <= rand_en ? 1'($urandom_range(0, 1)) : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic do_cfg(input logic [7:0] m, input logic [11:0] f, input logic [7:0] p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = m; cfg_fclk = f; cfg_pclk = p;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_ack(output int ticks);
    ticks = 0;
    forever begin
      @(posedge clk);
      if (vid_en) ticks++;
      #2;
      if (ack_w) break;
    end
  endtask

  initial begin
    int t;
    int lvl0;
    int pos;
    int bad;
    int seg_len[4] = '{354, 1224, 1884, 1078};
    int seg_lvl[4] = '{0, 2, 7, 2};

    // R1: reset state
    data_vld = 1'b1;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    check(level_w == 3'd0, "R1 level in reset", int'(level_w), 0);
    check(ack_w == 1'b0, "R1 ack in reset", int'(ack_w), 0);
    check(wait_w == 1'b0, "R1 wait in reset", int'(wait_w), 0);
    @(negedge clk);
    rst_n = 1'b1;
    data_vld = 1'b0;

    // R2 and R9: first frame 4096 enabled clocks under a sparse enable
    rand_en = 1'b1;
    pix_word = 32'h1B1B_E4E4; pal_word = 32'h472E_9DF0; data_vld = 1'b1;
    do_cfg(8'h01, 12'd64, 8'd4);
    wait_ack(t);
    check(t == 4096, "R2 R9 first frame ticks", t, 4096);
    pix_word = 32'h0F0F_3C3C; pal_word = 32'h1122_3344;
    wait_ack(t);
    check(t == 64, "R5 frame ticks", t, 64);

    // R3: halt holds everything
    repeat (20) @(negedge clk);
    do_cfg(8'h00, 12'd64, 8'd4);
    @(posedge clk); #2;
    lvl0 = int'(level_w);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #2;
      check(int'(level_w) == lvl0, "R3 level held while halted", int'(level_w), lvl0);
      check(ack_w == 1'b0, "R3 no ack while halted", int'(ack_w), 0);
      check(wait_w == 1'b0, "R10 wait low while halted", int'(wait_w), 0);
    end
    rand_en = 1'b0;
    pix_word = 32'hE4E4_E4E4; pal_word = 32'hC526_F3A1;
    do_cfg(8'h5A, 12'd100, 8'd2);
    wait_ack(t);
    check(t == 4096, "R3 restart frame ticks", t, 4096);

    // R7: pixel 15 (selector 3 -> entry 3, low bits 5) repeats
    repeat (80) @(posedge clk);
    #2;
    check(level_w == 3'd5, "R7 last pixel repeats", int'(level_w), 5);

    // R4/R10: bus taken at frame end without valid, no ack
    @(negedge clk);
    data_vld = 1'b0; pix_word = 32'h5555_5555; pal_word = 32'h0000_0C00;
    @(posedge clk); #2;
    check(wait_w == 1'b1, "R10 wait high without word", int'(wait_w), 1);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #2;
      check(ack_w == 1'b0, "R4 no ack without valid", int'(ack_w), 0);
    end
    check(level_w == 3'd4, "R4 reload from bus", int'(level_w), 4);

    // R5: zero frame count means 4096
    @(negedge clk);
    data_vld = 1'b1;
    do_cfg(8'h01, 12'd0, 8'd2);
    wait_ack(t);
    wait_ack(t);
    check(t == 4096, "R5 zero frame count", t, 4096);

    // R11: test line
    do_cfg(8'h00, 12'd0, 8'd2);
    pix_word = 32'h0; pal_word = 32'h0000_00F8; data_vld = 1'b1;
    rec_arm = 1'b1;
    do_cfg(8'h01, 12'd354, 8'd0);
    wait_ack(t);
    pal_word = 32'h0000_00FA;
    do_cfg(8'h01, 12'd1224, 8'd0);
    wait_ack(t);
    pal_word = 32'h0000_00FF;
    do_cfg(8'h01, 12'd1884, 8'd0);
    wait_ack(t);
    pal_word = 32'h0000_00FA;
    do_cfg(8'h01, 12'd1078, 8'd0);
    wait_ack(t);
    pal_word = 32'h0000_00FD;
    do_cfg(8'h01, 12'd50, 8'd0);
    while (rec_q.size() < 4541) @(posedge clk);
    #3;
    pos = 0;
    for (int s = 0; s < 4; s++) begin
      bad = 0;
      for (int j = 0; j < seg_len[s]; j++) begin
        if (rec_q[pos] != seg_lvl[s]) bad++;
        pos++;
      end
      check(bad == 0, "R11 segment mismatches", bad, 0);
    end
    check(rec_q[4540] == 5, "R11 line end", rec_q[4540], 5);
    finish_up();
  end
endmodule